// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Front End

This block is the register face of a simple serial port. A processor reaches it through a byte-wide bus with a 32-byte window. Behind the registers there are two byte paths. Outgoing bytes leave through a one-byte holding register with a valid/ready output. Incoming bytes arrive as single-cycle valid strobes and wait in a small receive queue until software drains them. The block also stores a 16-bit baud divisor that a separate bit-timing engine uses, and it drives one level-sensitive interrupt line.

Software polls or takes interrupts from a status byte. That byte reports transmit-empty, receive-empty, queue-full, a "one slot left" level, a sticky overflow flag and the two interrupt enables. The interrupt line is high whenever the transmit enable is set, because the outgoing side is treated as ready for more data. It is also high when the receive enable is set and the queue holds at least one byte.

A bus access completes on a rising edge where `bus_sel` and `bus_ready` are both high. Read data appears on `bus_rdata` in the cycle after the completing edge.

Top module: `uart_regfront`

## Requirements
- R1: Offsets 0x00, 0x04, 0x08 and 0x0C are identification registers. They read as 0x00 and ignore writes. Any offset with bits 1:0 not zero behaves the same way.
- R2: The status byte at offset 0x14 has these fields:
  - bit 7: transmit empty
  - bit 6: transmit interrupt enable
  - bit 5: receive queue empty
  - bit 4: queue holds exactly DEPTH-1 bytes
  - bit 3: queue full
  - bit 2: receive interrupt enable
  - bit 1: overflow
  - bit 0: frame error, which always reads 0
- R3: A read of the data register at offset 0x10 returns the oldest queued byte and removes it. Bytes come out in arrival order.
- R4: A byte arriving while the queue is full is dropped and the queue contents stay unchanged. If a data-register read completes in the same cycle, the arriving byte is accepted instead.
- R5: A dropped byte sets the overflow bit, and a status read clears it. A drop in the same cycle as a status read leaves the bit set. The read itself returns the value held before that edge.
- R6: A data-register read with an empty queue returns 0x00 and leaves the queue unchanged.
- R7: A data-register write places the byte on `tx_data` with `tx_valid` high. Both stay stable until `tx_ready` is seen. Status bit 7 reads 0 while the byte waits.
- R8: A data-register write while a byte is still waiting holds `bus_ready` low until the holding register is free.
- R9: A status write changes only the enables: bit 6 sets the transmit enable and bit 2 sets the receive enable.
- R10: `irq` is high exactly when the transmit enable is set, or when the receive enable is set and the queue is not empty.
- R11: Offset 0x18 holds divisor bits 7:0 and offset 0x1C holds bits 15:8. Each can be written and read back, and the full value appears on `baud_div`.
- R12: After reset the queue is empty, both enables and the divisor are zero, `irq` and `tx_valid` are low, and status reads 0xA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | Access completes on this edge when high |
| bus_rdata | output | 8 | Read data, valid the cycle after completion |
| tx_valid | output | 1 | Outgoing byte waiting |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Consumer takes the outgoing byte |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| irq | output | 1 | Level interrupt |
| baud_div | output | 16 | Stored baud divisor |

## Verification
Two pairs of events can fall in the same cycle, and both meet at a full receive queue.

The first pair is an incoming byte and a data-register read. The bench fills the queue to four entries, then drives `rx_valid` in the same cycle that it issues the data read. It judges the result by the status byte reading full with no overflow, and by all four remaining bytes draining in arrival order.

The second pair is a dropped byte and a status read. The bench drives both in one cycle. It expects that read to show no overflow, the next status read to show overflow, and the read after that to show it cleared.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  localparam int OFS_W = 5;

  // Status bit positions, which software decodes.
  localparam int ST_TXE  = 7;
  localparam int ST_TXIE = 6;
  localparam int ST_RXE  = 5;
  localparam int ST_ONE  = 4;
  localparam int ST_FULL = 3;
  localparam int ST_RXIE = 2;
  localparam int ST_OVF  = 1;
  localparam int ST_FERR = 0;

  typedef enum logic [2:0] {
    SEL_ID,
    SEL_DATA,
    SEL_STAT,
    SEL_BLO,
    SEL_BHI,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    reg_sel_e s;
    if (ofs[1:0] != 2'b00) begin
      s = SEL_NONE;
    end else begin
      case (ofs[4:2])
        3'd4:    s = SEL_DATA;
        3'd5:    s = SEL_STAT;
        3'd6:    s = SEL_BLO;
        3'd7:    s = SEL_BHI;
        default: s = SEL_ID;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic                         drop_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic pop_eff, push_eff;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == FULL_CNT);
  assign pop_eff  = pop_i && !empty_o;
  assign push_eff = push_i && (!full_o || pop_eff);
  assign drop_o   = push_i && !push_eff;
  assign count_o  = cnt_q;
  assign head_o   = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_eff) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_eff) wr_ptr <= wr_ptr + 1'b1;
      if (pop_eff)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_eff, pop_eff})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  // R4
  drop_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> $stable(cnt_q));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && empty_o && !push_i) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_txhold.sv
module uart_txhold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= load_data_i;
    end else if (vld_q && ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ready_i) |=> (vld_q && $stable(dat_q)));

  // R8
  no_load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !vld_q);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic             bus_ready,
  output logic [DW-1:0]    bus_rdata,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             irq,
  output logic [DIV_W-1:0] baud_div
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] ONE_LEFT = CW'(DEPTH-1);

  reg_sel_e sel;
  logic acc, wr_acc, rd_acc, pop, load;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt;
  logic q_empty, q_full, q_drop;
  logic tx_ie_q, rx_ie_q, ovf_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0] rdata_q, status;

  assign sel       = decode_ofs(bus_addr);
  assign bus_ready = !(bus_sel && bus_wr && (sel == SEL_DATA) && tx_valid);
  assign acc       = bus_sel && bus_ready;
  assign wr_acc    = acc && bus_wr;
  assign rd_acc    = acc && !bus_wr;
  assign pop       = rd_acc && (sel == SEL_DATA);
  assign load      = wr_acc && (sel == SEL_DATA);

  uart_rxq #(.DEPTH(DEPTH), .DW(DW)) i_rxq (
    .clk(clk), .rst(rst),
    .push_i(rx_valid), .push_data_i(rx_data), .pop_i(pop),
    .head_o(head), .count_o(cnt), .empty_o(q_empty),
    .full_o(q_full), .drop_o(q_drop)
  );

  uart_txhold #(.DW(DW)) i_txh (
    .clk(clk), .rst(rst),
    .load_i(load), .load_data_i(bus_wdata), .ready_i(tx_ready),
    .valid_o(tx_valid), .data_o(tx_data)
  );

  always_comb begin
    status          = '0;
    status[ST_TXE]  = !tx_valid;
    status[ST_TXIE] = tx_ie_q;
    status[ST_RXE]  = q_empty;
    status[ST_ONE]  = (cnt == ONE_LEFT);
    status[ST_FULL] = q_full;
    status[ST_RXIE] = rx_ie_q;
    status[ST_OVF]  = ovf_q;
    status[ST_FERR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
      ovf_q   <= 1'b0;
      div_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_acc) begin
        case (sel)
          SEL_STAT: begin
            tx_ie_q <= bus_wdata[ST_TXIE];
            rx_ie_q <= bus_wdata[ST_RXIE];
          end
          SEL_BLO: div_q[7:0]       <= bus_wdata;
          SEL_BHI: div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
          default: ;
        endcase
      end
      if (q_drop)                             ovf_q <= 1'b1;
      else if (rd_acc && (sel == SEL_STAT))   ovf_q <= 1'b0;
      if (rd_acc) begin
        case (sel)
          SEL_DATA: rdata_q <= head;
          SEL_STAT: rdata_q <= status;
          SEL_BLO:  rdata_q <= div_q[7:0];
          SEL_BHI:  rdata_q <= DW'(div_q[DIV_W-1:8]);
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign baud_div  = div_q;
  assign irq       = tx_ie_q || (rx_ie_q && !q_empty);

  // R1
  id_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && (sel == SEL_ID || sel == SEL_NONE)) |=> (bus_rdata == '0));

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    q_drop |=> ovf_q);

  // R11
  baud_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && sel == SEL_BLO) |=> (baud_div[7:0] == $past(bus_wdata)));

  // R10
  irq_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && sel == SEL_STAT && bus_wdata[ST_TXIE]) |=> irq);

endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
  logic clk = 0;
  logic rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_ready;
  logic [7:0] bus_rdata;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic irq;
  logic [15:0] baud_div;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_regfront i_uart_regfront (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .irq(irq), .baud_div(baud_div)
  );

  localparam logic [4:0] A_DATA = 5'h10, A_STAT = 5'h14, A_BLO = 5'h18, A_BHI = 5'h1C;

  // {is_read, addr, wdata, expected}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 5'h14, 8'h00, 8'hA0},  // R12 status after reset
    {1'b1, 5'h18, 8'h00, 8'h00},  // R12 divisor low
    {1'b1, 5'h1C, 8'h00, 8'h00},  // R12 divisor high
    {1'b0, 5'h18, 8'h34, 8'h00},  // R11
    {1'b0, 5'h1C, 8'h12, 8'h00},  // R11
    {1'b1, 5'h18, 8'h00, 8'h34},  // R11
    {1'b1, 5'h1C, 8'h00, 8'h12},  // R11
    {1'b0, 5'h04, 8'hFF, 8'h00},  // R1
    {1'b1, 5'h04, 8'h00, 8'h00},  // R1
    {1'b0, 5'h05, 8'hFF, 8'h00},  // R1 unaligned
    {1'b1, 5'h05, 8'h00, 8'h00},  // R1
    {1'b0, 5'h14, 8'hFF, 8'h00},  // R9
    {1'b1, 5'h14, 8'h00, 8'hE4},  // R9
    {1'b0, 5'h14, 8'h00, 8'h00},  // R9
    {1'b1, 5'h10, 8'h00, 8'h00}   // R6 empty read
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [7:0] d, output int stalls);
    logic r;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    stalls = 0; r = 0;
    while (!r) begin
      #1 r = bus_ready;
      @(posedge clk);
      if (!r) begin stalls++; @(negedge clk); end
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic read_with_push(logic [4:0] a, logic [7:0] b, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    rx_valid = 1; rx_data = b;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0; rx_valid = 0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int st;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R12 irq", {15'd0, irq}, 16'd0);
    check("R12 tx_valid", {15'd0, tx_valid}, 16'd0);
    check("R12 baud_div", baud_div, 16'd0);
    check("R12 bus_ready", {15'd0, bus_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        bus_read(VEC[i][20:16], d);
        check($sformatf("vector %0d", i), {8'd0, d}, {8'd0, VEC[i][7:0]});
      end else begin
        bus_write(VEC[i][20:16], VEC[i][15:8], st);
      end
    end
    check("R11 baud_div port", baud_div, 16'h1234);

    // Queue order, level bits, drop and overflow (R2 R3 R4 R5)
    push(8'hA1); push(8'hA2); push(8'hA3);
    bus_read(A_STAT, d); check("R2 one slot left", {8'd0, d}, 16'h0090);
    push(8'hA4);
    bus_read(A_STAT, d); check("R2 full", {8'd0, d}, 16'h0088);
    push(8'hA5);
    bus_read(A_STAT, d); check("R5 overflow set", {8'd0, d}, 16'h008A);
    bus_read(A_STAT, d); check("R5 overflow cleared", {8'd0, d}, 16'h0088);
    for (int k = 0; k < 4; k++) begin
      bus_read(A_DATA, d);
      check("R3 R4 order after drop", {8'd0, d}, {8'd0, 8'hA1 + 8'(k)});
    end
    bus_read(A_STAT, d); check("R2 empty again", {8'd0, d}, 16'h00A0);

    // Pop and push at full in one cycle (R4)
    push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
    read_with_push(A_DATA, 8'hB5, d);
    check("R4 same-cycle read data", {8'd0, d}, 16'h00B1);
    bus_read(A_STAT, d); check("R4 same-cycle no drop", {8'd0, d}, 16'h0088);
    for (int k = 0; k < 4; k++) begin
      bus_read(A_DATA, d);
      check("R4 same-cycle order", {8'd0, d}, {8'd0, 8'hB2 + 8'(k)});
    end

    // Drop during a status read (R5)
    push(8'hC1); push(8'hC2); push(8'hC3); push(8'hC4);
    read_with_push(A_STAT, 8'hC5, d);
    check("R5 status read before drop", {8'd0, d}, 16'h0088);
    bus_read(A_STAT, d); check("R5 drop wins over clear", {8'd0, d}, 16'h008A);
    bus_read(A_STAT, d); check("R5 cleared next read", {8'd0, d}, 16'h0088);
    for (int k = 0; k < 4; k++) begin
      bus_read(A_DATA, d);
      check("R4 contents kept", {8'd0, d}, {8'd0, 8'hC1 + 8'(k)});
    end
    bus_read(A_DATA, d); check("R6 empty read zero", {8'd0, d}, 16'h0000);
    bus_read(A_STAT, d); check("R6 still empty", {8'd0, d}, 16'h00A0);

    // Interrupt (R10)
    bus_write(A_STAT, 8'h40, st); #1 check("R10 tx enable irq", {15'd0, irq}, 16'd1);
    bus_write(A_STAT, 8'h04, st); #1 check("R10 rx enable empty", {15'd0, irq}, 16'd0);
    push(8'h77); #1 check("R10 rx data irq", {15'd0, irq}, 16'd1);
    bus_read(A_DATA, d); #1 check("R10 irq drops", {15'd0, irq}, 16'd0);
    check("R3 single byte", {8'd0, d}, 16'h0077);
    bus_write(A_STAT, 8'h00, st);

    // Transmit path (R7 R8)
    bus_write(A_DATA, 8'h55, st);
    #1 check("R7 tx_valid", {15'd0, tx_valid}, 16'd1);
    check("R7 tx_data", {8'd0, tx_data}, 16'h0055);
    bus_read(A_STAT, d); check("R7 tx not empty", {8'd0, d}, 16'h0020);
    fork
      bus_write(A_DATA, 8'h66, st);
      begin
        repeat (4) @(negedge clk);
        #2;
        check("R8 bus_ready low", {15'd0, bus_ready}, 16'd0);
        check("R7 held data", {7'd0, tx_valid, tx_data}, 16'h0155);
        @(negedge clk); tx_ready = 1;
        @(negedge clk); tx_ready = 0;
      end
    join
    check("R8 stalled", {15'd0, st > 0}, 16'd1);
    #1 check("R7 second byte", {7'd0, tx_valid, tx_data}, 16'h0166);
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    check("R7 drained", {15'd0, tx_valid}, 16'd0);
    bus_read(A_STAT, d); check("R7 tx empty", {8'd0, d}, 16'h00A0);

    done = 1;
    finish_run();
  end
endmodule